// File: doc/BRIEF.md
# LCD Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal and vertical sync, a data-enable strobe, and the current pixel coordinates. A pixel-rate enable is derived from the system clock by a programmable divider. All geometry comes from a small set of 32-bit configuration words written through a simple write port. Each geometry word carries a horizontal quantity in its low 16 bits and a vertical quantity in its high 16 bits.

A line is laid out as the active pixels, then the front porch, then the sync pulse, then the back porch. A frame is built from lines in the same order. A start-of-frame strobe is raised once per frame for the interrupt logic that counts frames.

Written words first go to a staging copy. They reach the raster logic only at the end of the frame, so the frame on screen always uses one consistent set of values.

Top module: `lcd_timing_gen`

## Requirements
- R1: Geometry words are written to addresses 0 to 3. Address 0 holds the hsync width minus one in bits [15:0] and the vsync width minus one in bits [31:16]. Address 2 holds the horizontal front porch minus one in bits [15:0] and the horizontal back porch minus one in bits [31:16]. Address 3 holds the active width minus one in bits [15:0] and the active height minus one in bits [31:16]. One frame lasts (line length × line count) pixel periods.
- R2: Address 1 holds the vertical front porch minus one in bits [15:0]. Bits [31:16] hold the vertical back porch in lines, not decremented, and a value of 0 gives no back-porch lines.
- R3: Within a line, the order is active, front porch, sync, back porch. Frames follow the same order in lines. `hsync` asserts exactly front-porch pixel periods after `de` falls. Sync is never asserted while `de` is high.
- R4: `de` is high only for active pixels of active lines, which is width × height pixel periods per frame.
- R5: The control word at address 4 holds the divider in bits [7:0]. Bit 8 set selects a source at twice the system clock, giving one pixel per divider/2 clocks. Bit 8 clear selects the system clock, giving one pixel per divider clocks.
- R6: A divider value below 2 behaves exactly as 2.
- R7: Control bit 9 makes `hsync` active-low and control bit 10 makes `vsync` active-low. When a bit is clear, its sync is active-high.
- R8: `sof` is a one-clock pulse, once per frame, in the last clock of the first pixel of the frame. While it is high, `de` is 1 and the coordinates are (0,0).
- R9: Written values take effect only at the next frame boundary. The frame in progress while a write happens keeps the old timing.
- R10: During and right after reset, `hsync`, `vsync` and `sof` are low and the coordinates are (0,0). The timing comes from the parameter defaults.
- R11: During `de`, `pix_x` runs from 0 to width−1 and `pix_y` runs from 0 to height−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word address (0–4) |
| cfg_wdata | input | 32 | Configuration write data |
| hsync | output | 1 | Horizontal sync, polarity per control bit 9 |
| vsync | output | 1 | Vertical sync, polarity per control bit 10 |
| de | output | 1 | Data enable, high on active pixels |
| pix_x | output | 16 | Horizontal pixel position in the line |
| pix_y | output | 16 | Line position in the frame |
| sof | output | 1 | Start-of-frame pulse |

## Verification
The bench builds the block with its default parameters: 16-bit fields, an 8-bit divider and a reset geometry of 8×4 active pixels inside a 14×7 raster. Frames therefore last from about a hundred to a few hundred clocks. This keeps a dozen reprogrammings within easy reach: zero and nonzero vertical back porch, fractional and whole divider ratios, both source rates, below-minimum dividers and inverted polarities. Each setting is judged from per-frame counts of clocks, `de` and sync cycles, measured between `sof` pulses.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
    parameter int unsigned TG_CW = 16;  // width of one timing field
    parameter int unsigned TG_DW = 8;   // width of the divider field
    parameter int unsigned TG_AW = 3;   // config address width
    parameter int unsigned TG_RW = 32;  // config word width

    typedef enum logic [TG_AW-1:0] {
        REG_SYNCW  = 3'd0,
        REG_VPORCH = 3'd1,
        REG_HPORCH = 3'd2,
        REG_SIZE   = 3'd3,
        REG_CTRL   = 3'd4
    } tg_reg_e;

    typedef struct packed {
        logic [TG_CW-1:0] hsw_m1;
        logic [TG_CW-1:0] vsw_m1;
        logic [TG_CW-1:0] vfp_m1;
        logic [TG_CW-1:0] vbp;
        logic [TG_CW-1:0] hfp_m1;
        logic [TG_CW-1:0] hbp_m1;
        logic [TG_CW-1:0] hact_m1;
        logic [TG_CW-1:0] vact_m1;
        logic [TG_DW-1:0] div;
        logic             dbl;
        logic             inv_h;
        logic             inv_v;
    } tg_cfg_t;
endpackage

// File: rtl/lcd_tg_pixdiv.sv
module lcd_tg_pixdiv #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] div,
    input  logic          dbl,
    output logic          tick
);
    localparam int unsigned AW = DW + 1;

    typedef struct packed {
        logic [AW-1:0] acc;
        logic          tick;
    } div_st_t;

    div_st_t st_q, st_d;
    logic [AW-1:0] div_eff, inc, sum, rem;

    always_comb begin
        st_d    = st_q;
        div_eff = (div < DW'(2)) ? AW'(2) : {1'b0, div};
        inc     = dbl ? AW'(2) : AW'(1);
        sum     = st_q.acc + inc;
        rem     = sum - div_eff;
        if (sum >= div_eff) begin
            st_d.tick = 1'b1;
            st_d.acc  = (rem >= div_eff) ? '0 : rem;
        end else begin
            st_d.tick = 1'b0;
            st_d.acc  = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

    AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dbl && !$past(dbl) && $stable(div)) |=> !tick); // R6
endmodule

// File: rtl/lcd_tg_scan.sv
module lcd_tg_scan #(
    parameter int unsigned CW = 16,
    parameter int unsigned LW = CW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [LW-1:0] h_act,
    input  logic [LW-1:0] h_ss,
    input  logic [LW-1:0] h_se,
    input  logic [LW-1:0] h_tot,
    input  logic [LW-1:0] v_act,
    input  logic [LW-1:0] v_ss,
    input  logic [LW-1:0] v_se,
    input  logic [LW-1:0] v_tot,
    output logic [CW-1:0] x_pos,
    output logic [CW-1:0] y_pos,
    output logic          de,
    output logic          hs_on,
    output logic          vs_on,
    output logic          frame_wrap,
    output logic          frame_start
);
    typedef struct packed {
        logic [LW-1:0] h;
        logic [LW-1:0] v;
    } scan_st_t;

    scan_st_t st_q, st_d;
    logic h_last, v_last;

    always_comb begin
        st_d   = st_q;
        h_last = (st_q.h == h_tot - LW'(1));
        v_last = (st_q.v == v_tot - LW'(1));
        if (tick) begin
            if (h_last) begin
                st_d.h = '0;
                st_d.v = v_last ? '0 : st_q.v + LW'(1);
            end else begin
                st_d.h = st_q.h + LW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign de          = (st_q.h < h_act) && (st_q.v < v_act);
    assign hs_on       = (st_q.h >= h_ss) && (st_q.h < h_se);
    assign vs_on       = (st_q.v >= v_ss) && (st_q.v < v_se);
    assign frame_wrap  = tick && h_last && v_last;
    assign frame_start = tick && (st_q.h == '0) && (st_q.v == '0);
    assign x_pos       = st_q.h[CW-1:0];
    assign y_pos       = st_q.v[CW-1:0];

    AST_H_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.h < h_tot); // R1
    AST_DE_EXCL_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (!hs_on && !vs_on)); // R3
    AST_SOF_ON_DE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> de); // R8
    AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start); // R8
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcd_tg_pkg::*;
#(
    parameter int unsigned DEF_HACT = 8,
    parameter int unsigned DEF_HFP  = 2,
    parameter int unsigned DEF_HSW  = 2,
    parameter int unsigned DEF_HBP  = 2,
    parameter int unsigned DEF_VACT = 4,
    parameter int unsigned DEF_VFP  = 1,
    parameter int unsigned DEF_VSW  = 1,
    parameter int unsigned DEF_VBP  = 1,
    parameter int unsigned DEF_DIV  = 2,
    parameter bit          DEF_DBL  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [TG_AW-1:0] cfg_addr,
    input  logic [TG_RW-1:0] cfg_wdata,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [TG_CW-1:0] pix_x,
    output logic [TG_CW-1:0] pix_y,
    output logic             sof
);
    localparam int unsigned LW = TG_CW + 2;
    localparam int unsigned HW = TG_RW / 2;

    localparam tg_cfg_t CFG_RST = '{
        hsw_m1:  TG_CW'(DEF_HSW - 1),
        vsw_m1:  TG_CW'(DEF_VSW - 1),
        vfp_m1:  TG_CW'(DEF_VFP - 1),
        vbp:     TG_CW'(DEF_VBP),
        hfp_m1:  TG_CW'(DEF_HFP - 1),
        hbp_m1:  TG_CW'(DEF_HBP - 1),
        hact_m1: TG_CW'(DEF_HACT - 1),
        vact_m1: TG_CW'(DEF_VACT - 1),
        div:     TG_DW'(DEF_DIV),
        dbl:     DEF_DBL,
        inv_h:   1'b0,
        inv_v:   1'b0
    };

    typedef struct packed {
        tg_cfg_t stage;
        tg_cfg_t act;
    } top_st_t;

    top_st_t st_q, st_d;
    logic [TG_CW-1:0] w_lo, w_hi;
    logic tick, frame_wrap, hs_on, vs_on;
    logic [LW-1:0] h_act, h_ss, h_se, h_tot, v_act, v_ss, v_se, v_tot;

    assign w_lo = cfg_wdata[HW-1:0];
    assign w_hi = cfg_wdata[TG_RW-1:HW];

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            case (cfg_addr)
                REG_SYNCW:  begin st_d.stage.hsw_m1  = w_lo; st_d.stage.vsw_m1  = w_hi; end
                REG_VPORCH: begin st_d.stage.vfp_m1  = w_lo; st_d.stage.vbp     = w_hi; end
                REG_HPORCH: begin st_d.stage.hfp_m1  = w_lo; st_d.stage.hbp_m1  = w_hi; end
                REG_SIZE:   begin st_d.stage.hact_m1 = w_lo; st_d.stage.vact_m1 = w_hi; end
                REG_CTRL: begin
                    st_d.stage.div   = cfg_wdata[TG_DW-1:0];
                    st_d.stage.dbl   = cfg_wdata[TG_DW];
                    st_d.stage.inv_h = cfg_wdata[TG_DW+1];
                    st_d.stage.inv_v = cfg_wdata[TG_DW+2];
                end
                default: ;
            endcase
        end
        if (frame_wrap) st_d.act = st_q.stage;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{stage: CFG_RST, act: CFG_RST};
        else        st_q <= st_d;
    end

    // segment boundaries: active | front porch | sync | back porch
    always_comb begin
        h_act = LW'(st_q.act.hact_m1) + LW'(1);
        h_ss  = h_act + LW'(st_q.act.hfp_m1) + LW'(1);
        h_se  = h_ss  + LW'(st_q.act.hsw_m1) + LW'(1);
        h_tot = h_se  + LW'(st_q.act.hbp_m1) + LW'(1);
        v_act = LW'(st_q.act.vact_m1) + LW'(1);
        v_ss  = v_act + LW'(st_q.act.vfp_m1) + LW'(1);
        v_se  = v_ss  + LW'(st_q.act.vsw_m1) + LW'(1);
        v_tot = v_se  + LW'(st_q.act.vbp);
    end

    lcd_tg_pixdiv #(.DW(TG_DW)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (st_q.act.div),
        .dbl  (st_q.act.dbl),
        .tick (tick)
    );

    lcd_tg_scan #(.CW(TG_CW), .LW(LW)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .h_act      (h_act),
        .h_ss       (h_ss),
        .h_se       (h_se),
        .h_tot      (h_tot),
        .v_act      (v_act),
        .v_ss       (v_ss),
        .v_se       (v_se),
        .v_tot      (v_tot),
        .x_pos      (pix_x),
        .y_pos      (pix_y),
        .de         (de),
        .hs_on      (hs_on),
        .vs_on      (vs_on),
        .frame_wrap (frame_wrap),
        .frame_start(sof)
    );

    assign hsync = hs_on ^ st_q.act.inv_h;
    assign vsync = vs_on ^ st_q.act.inv_v;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_wrap |=> $stable(st_q.act)); // R9
    AST_POL_H: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (hsync == st_q.act.inv_h)); // R7
endmodule

// File: tb/sim_lcd_timing_gen.sv
module sim_lcd_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        hsync, vsync, de, sof;
    logic [15:0] pix_x, pix_y;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk; // 50 MHz

    lcd_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .hsync(hsync), .vsync(vsync), .de(de),
        .pix_x(pix_x), .pix_y(pix_y), .sof(sof)
    );

    // per-frame monitor
    int frames = 0, gcyc = 0;
    int f_cyc = 0, f_de = 0, f_hs = 0, f_vs = 0, f_mx = 0, f_my = 0;
    int l_cyc = 0, l_de = 0, l_hs = 0, l_vs = 0, l_mx = 0, l_my = 0, l_gap = 0;
    int gap = -1, t0 = 0, sof_bad = 0;
    bit armed = 0, de_p = 0, hs_p = 0, sof_p = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            gcyc++;
            if (de_p && !de) begin armed = 1; t0 = gcyc; end
            if (hsync && !hs_p && armed) begin gap = gcyc - t0; armed = 0; end
            if (sof && sof_p) sof_bad++;
            if (sof && !(de && pix_x == 0 && pix_y == 0)) sof_bad++;
            if (sof) begin
                l_cyc = f_cyc; l_de = f_de; l_hs = f_hs; l_vs = f_vs;
                l_mx = f_mx; l_my = f_my; l_gap = gap;
                f_cyc = 0; f_de = 0; f_hs = 0; f_vs = 0; f_mx = 0; f_my = 0;
            end
            f_cyc++;
            if (de) f_de++;
            if (hsync) f_hs++;
            if (vsync) f_vs++;
            if (de && int'(pix_x) > f_mx) f_mx = int'(pix_x);
            if (de && int'(pix_y) > f_my) f_my = int'(pix_y);
            de_p = de; hs_p = hsync; sof_p = sof;
            if (sof) frames++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_frame();
        int f;
        f = frames;
        wait (frames != f);
    endtask

    task automatic settle();
        wait_frame(); wait_frame();
    endtask

    function automatic logic [31:0] pk(input int hi, input int lo);
        return {16'(hi), 16'(lo)};
    endfunction

    task automatic t_reset();
        #1;
        check("R10 hsync", int'(hsync), 0);
        check("R10 vsync", int'(vsync), 0);
        check("R10 sof", int'(sof), 0);
        check("R10 xy", int'(pix_x) + int'(pix_y), 0);
    endtask

    task automatic t_default();
        settle();
        check("R10 R1 default period", l_cyc, 98);
        check("R4 de count", l_de, 32);
        check("R3 hfp gap", l_gap, 2);
        check("R7 hs active-high count", l_hs, 14);
        check("R7 vs active-high count", l_vs, 14);
        check("R11 max x", l_mx, 7);
        check("R11 max y", l_my, 3);
    endtask

    task automatic t_geometry();
        wr(3'd0, pk(1, 0));   // hsw 1, vsw 2
        wr(3'd1, pk(0, 1));   // vfp 2, vbp 0
        wr(3'd2, pk(3, 2));   // hfp 3, hbp 4
        wr(3'd3, pk(4, 9));   // 10 x 5
        settle();
        check("R1 R2 period vbp0", l_cyc, 162);
        check("R4 de count", l_de, 50);
        check("R3 hfp gap", l_gap, 3);
        check("R1 hs count", l_hs, 9);
        check("R1 vs count", l_vs, 36);
        check("R11 max x", l_mx, 9);
        check("R11 max y", l_my, 4);
    endtask

    task automatic t_vbp();
        wr(3'd1, pk(3, 1));
        settle();
        check("R2 period vbp3", l_cyc, 216);
    endtask

    task automatic t_clock();
        wr(3'd4, 32'h0000_0002);
        settle();
        check("R5 sys source div2", l_cyc, 432);
        wr(3'd4, 32'h0000_0103);
        settle();
        check("R5 double source div3", l_cyc, 324);
        wr(3'd4, 32'h0000_0003);
        settle();
        check("R5 sys source div3", l_cyc, 648);
    endtask

    task automatic t_floor();
        wr(3'd4, 32'h0000_0000);
        settle();
        check("R6 div0 as 2", l_cyc, 432);
        wr(3'd4, 32'h0000_0101);
        settle();
        check("R6 div1 as 2", l_cyc, 216);
    endtask

    task automatic t_polarity();
        wr(3'd4, 32'h0000_0702);
        settle();
        check("R7 hs active-low", l_hs, 204);
        check("R7 vs active-low", l_vs, 180);
        check("R4 de unchanged", l_de, 50);
        wr(3'd4, 32'h0000_0102);
        settle();
    endtask

    task automatic t_shadow();
        wait_frame();
        repeat (20) @(negedge clk);
        wr(3'd3, pk(4, 3));   // width 4
        wait_frame();
        check("R9 old timing kept", l_cyc, 216);
        wait_frame();
        check("R9 new timing", l_cyc, 144);
        check("R8 sof shape", sof_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_default();
        t_geometry();
        t_vbp();
        t_clock();
        t_floor();
        t_polarity();
        t_shadow();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog R9 actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule